// File: doc/BRIEF.md
# Fast-Lock Loop Bandwidth Sequencer

This block runs the bandwidth-switching sequence that follows every frequency load of a fractional-N synthesizer loop. A single-cycle load strobe puts the loop into its wide state. In that state the charge-pump current select carries the boosted code, and both groups of loop-filter bypass switches are closed. From then on the block counts reference (phase-detector) cycles, which arrive as a one-cycle enable on the fast system clock.

Two independent timers stage the narrowing of the loop. When the first timer expires, the switch pair opens and the charge-pump current drops to its normal code. When the second timer expires, the single third switch opens. The two timeout values are captured at the load, so every switching event lands on a known reference cycle counted from that load. A status output goes high once both timers of the current sequence have expired.

A load that arrives while a sequence is running restarts that sequence. The count continues from the new load, using the newly captured timeouts.

Top module: `fastlock_seq`

## Requirements
- R1: After reset both switch outputs are low (open), `cp_sel` carries the narrow code `CP_NARROW`, and `settled` is low.
- R2: In the clock cycle after `load` is sampled high, `sw_pair_closed` and `sw_third_closed` are both high and `cp_sel` equals `CP_WIDE`.
- R3: Only `load` starts a sequence. Reference enables alone, whether before the first load or after a sequence has finished, leave every output unchanged.
- R4: With a captured pair timeout Tp, `sw_pair_closed` falls in the cycle after the (Tp+1)-th `pfd_en` pulse that follows the load. A pulse in the same cycle as `load` is not counted, and Tp = 0 opens the pair on the first reference cycle after the load.
- R5: The third switch opens after its own captured timeout Tt in the same way, independently of the pair timer. It may open before, with, or after the pair.
- R6: `cp_sel` equals `CP_WIDE` exactly while `sw_pair_closed` is high, and equals `CP_NARROW` otherwise.
- R7: Both timeout inputs are sampled only in the `load` cycle. Changes to them at any other time have no effect on the running sequence.
- R8: A `load` during an active sequence re-enters the wide state and restarts both counts from zero with the newly sampled timeouts.
- R9: `settled` is high exactly when a sequence has been started and both of its timers have expired. A `load` clears it in the following cycle.
- R10: Only clock cycles with `pfd_en` high advance the timers. Any number of idle clock cycles between reference enables does not change the switching point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pfd_en | input | 1 | One-cycle pulse per reference (PFD) cycle |
| load | input | 1 | Frequency-load strobe; starts or restarts the sequence |
| pair_timeout | input | TMR_W | Reference cycles (minus one) before the switch pair opens |
| third_timeout | input | TMR_W | Reference cycles (minus one) before the third switch opens |
| cp_sel | output | CP_W | Charge-pump current code, boosted or narrow |
| sw_pair_closed | output | 1 | High closes the first bypass switch pair |
| sw_third_closed | output | 1 | High closes the third bypass switch |
| settled | output | 1 | Both timers of the current sequence have expired |

## Verification
The hardest situations to reach are those where a load and a reference enable coincide, or where a load cuts into a sequence that is only partly finished. Those are the cases in which an off-by-one in the counting or a stale captured timeout would show up. The bench sweeps every pair of timeout values in a 4-bit configuration. On alternate runs it places a reference enable in the load cycle itself, and it rotates the reference enable spacing among one, two and three clocks. Between loads it drives unrelated values on the timeout inputs. A final directed run reloads the block part-way through a sequence, with a simultaneous reference enable and a shorter pair of timeouts.

// File: rtl/fastlock_pkg.sv
package fastlock_pkg;
   localparam int NUM_STAGES = 2;
   localparam int STG_PAIR   = 0;
   localparam int STG_THIRD  = 1;

   typedef enum logic {
      CNT_UP   = 1'b0,
      CNT_DOWN = 1'b1
   } cnt_style_t;
endpackage

// File: rtl/fl_stage_timer.sv
module fl_stage_timer
   import fastlock_pkg::*;
#(
   parameter int         TMR_W = 11,
   parameter cnt_style_t STYLE = CNT_UP
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             tick,
   input  logic [TMR_W-1:0] timeout,
   output logic             closed_o,
   output logic             expired_o
);
   logic             armed;
   logic             done;
   logic [TMR_W-1:0] cnt;

   generate
      if (STYLE == CNT_DOWN) begin : g_down
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               armed <= 1'b0;
               done  <= 1'b0;
               cnt   <= '0;
            end else if (start) begin
               armed <= 1'b1;
               done  <= 1'b0;
               cnt   <= timeout;
            end else if (tick && armed) begin
               if (cnt == '0) begin
                  armed <= 1'b0;
                  done  <= 1'b1;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
         end
      end else begin : g_up
         logic [TMR_W-1:0] limit;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               armed <= 1'b0;
               done  <= 1'b0;
               cnt   <= '0;
               limit <= '0;
            end else if (start) begin
               armed <= 1'b1;
               done  <= 1'b0;
               cnt   <= '0;
               limit <= timeout;
            end else if (tick && armed) begin
               if (cnt == limit) begin
                  armed <= 1'b0;
                  done  <= 1'b1;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
         end
      end
   endgenerate

   assign closed_o  = armed;
   assign expired_o = done;
endmodule

// File: rtl/fastlock_seq.sv
module fastlock_seq
   import fastlock_pkg::*;
#(
   parameter int         TMR_W     = 11,
   parameter int         CP_W      = 4,
   parameter int         CP_WIDE   = 8,
   parameter int         CP_NARROW = 1,
   parameter cnt_style_t STYLE     = CNT_UP
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pfd_en,
   input  logic             load,
   input  logic [TMR_W-1:0] pair_timeout,
   input  logic [TMR_W-1:0] third_timeout,
   output logic [CP_W-1:0]  cp_sel,
   output logic             sw_pair_closed,
   output logic             sw_third_closed,
   output logic             settled
);
   localparam logic [CP_W-1:0] WIDE_CODE   = CP_W'(CP_WIDE);
   localparam logic [CP_W-1:0] NARROW_CODE = CP_W'(CP_NARROW);

   generate
      if (TMR_W < 1) begin : g_bad_tmr
         $error("fastlock_seq: TMR_W must be at least 1");
      end
      if (CP_WIDE <= CP_NARROW) begin : g_bad_cp_order
         $error("fastlock_seq: boosted code must exceed narrow code");
      end
      if (CP_WIDE >= (1 << CP_W) || CP_NARROW < 0) begin : g_bad_cp_range
         $error("fastlock_seq: charge-pump codes do not fit CP_W");
      end
   endgenerate

   logic [TMR_W-1:0] stage_to      [NUM_STAGES];
   logic             stage_closed  [NUM_STAGES];
   logic             stage_expired [NUM_STAGES];

   assign stage_to[STG_PAIR]  = pair_timeout;
   assign stage_to[STG_THIRD] = third_timeout;

   generate
      for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
         fl_stage_timer #(
            .TMR_W (TMR_W),
            .STYLE (STYLE)
         ) u_timer (
            .clk       (clk),
            .rst_n     (rst_n),
            .start     (load),
            .tick      (pfd_en),
            .timeout   (stage_to[s]),
            .closed_o  (stage_closed[s]),
            .expired_o (stage_expired[s])
         );
      end
   endgenerate

   assign sw_pair_closed  = stage_closed[STG_PAIR];
   assign sw_third_closed = stage_closed[STG_THIRD];
   assign cp_sel          = stage_closed[STG_PAIR] ? WIDE_CODE : NARROW_CODE;
   assign settled         = stage_expired[STG_PAIR] & stage_expired[STG_THIRD];
endmodule

// File: rtl/fastlock_seq_chk.sv
module fastlock_seq_chk #(
   parameter int TMR_W     = 11,
   parameter int CP_W      = 4,
   parameter int CP_WIDE   = 8,
   parameter int CP_NARROW = 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             pfd_en,
   input logic             load,
   input logic [TMR_W-1:0] pair_timeout,
   input logic [TMR_W-1:0] third_timeout,
   input logic [CP_W-1:0]  cp_sel,
   input logic             sw_pair_closed,
   input logic             sw_third_closed,
   input logic             settled
);
   logic [TMR_W:0]   ref_cnt;
   logic [TMR_W-1:0] cap_pair;
   logic [TMR_W-1:0] cap_third;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_cnt   <= '0;
         cap_pair  <= '0;
         cap_third <= '0;
      end else if (load) begin
         ref_cnt   <= '0;
         cap_pair  <= pair_timeout;
         cap_third <= third_timeout;
      end else if (pfd_en && ref_cnt != '1) begin
         ref_cnt <= ref_cnt + 1'b1;
      end
   end

   assert_load_wide_R2: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (sw_pair_closed && sw_third_closed && cp_sel == CP_W'(CP_WIDE)));

   assert_pair_time_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sw_pair_closed) |-> (ref_cnt == {1'b0, cap_pair} + 1'b1));

   assert_third_time_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sw_third_closed) |-> (ref_cnt == {1'b0, cap_third} + 1'b1));

   assert_cp_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cp_sel == CP_W'(CP_WIDE)) == sw_pair_closed);

   assert_no_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !sw_pair_closed && !sw_third_closed) |=> (!sw_pair_closed && !sw_third_closed));

   assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !pfd_en) |=> ($stable(sw_pair_closed) && $stable(sw_third_closed) && $stable(settled)));

   assert_settled_open_R9: assert property (@(posedge clk) disable iff (!rst_n)
      settled |-> (!sw_pair_closed && !sw_third_closed));

   assert_load_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> !settled);
endmodule

bind fastlock_seq fastlock_seq_chk #(
   .TMR_W     (TMR_W),
   .CP_W      (CP_W),
   .CP_WIDE   (CP_WIDE),
   .CP_NARROW (CP_NARROW)
) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .pfd_en          (pfd_en),
   .load            (load),
   .pair_timeout    (pair_timeout),
   .third_timeout   (third_timeout),
   .cp_sel          (cp_sel),
   .sw_pair_closed  (sw_pair_closed),
   .sw_third_closed (sw_third_closed),
   .settled         (settled)
);

// File: tb/fastlock_seq_bench.sv
`timescale 1ns/1ps
module fastlock_seq_bench;
   localparam int TW     = 4;
   localparam int CPW    = 4;
   localparam int WIDE   = 8;
   localparam int NARROW = 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          pfd_en = 1'b0;
   logic          load = 1'b0;
   logic [TW-1:0] pair_timeout = '0;
   logic [TW-1:0] third_timeout = '0;
   logic [CPW-1:0] cp_sel;
   logic          sw_pair_closed;
   logic          sw_third_closed;
   logic          settled;

   int total = 0;
   int fails = 0;

   int  ticks = 0;
   int  cap_p = 0;
   int  cap_t = 0;
   bit  started = 0;
   int  junk = 5;

   always #2 clk = ~clk;

   fastlock_seq #(
      .TMR_W     (TW),
      .CP_W      (CPW),
      .CP_WIDE   (WIDE),
      .CP_NARROW (NARROW)
   ) u_fastlock_seq (
      .clk             (clk),
      .rst_n           (rst_n),
      .pfd_en          (pfd_en),
      .load            (load),
      .pair_timeout    (pair_timeout),
      .third_timeout   (third_timeout),
      .cp_sel          (cp_sel),
      .sw_pair_closed  (sw_pair_closed),
      .sw_third_closed (sw_third_closed),
      .settled         (settled)
   );

   task automatic chk(input int act, input int exp, input string what);
      total++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", what, act, exp);
      end
   endtask

   task automatic check_all(input string ctx);
      bit ep, et;
      ep = started && (ticks <= cap_p);
      et = started && (ticks <= cap_t);
      chk(sw_pair_closed, ep, {ctx, " pair switch R4"});
      chk(sw_third_closed, et, {ctx, " third switch R5"});
      chk(cp_sel, ep ? WIDE : NARROW, {ctx, " cp code R6"});
      chk(settled, started && !ep && !et, {ctx, " settled R9"});
   endtask

   task automatic step(input bit ld, input bit tk, input int p, input int t, input string ctx);
      @(negedge clk);
      load  = ld;
      pfd_en = tk;
      if (ld) begin
         pair_timeout  = TW'(p);
         third_timeout = TW'(t);
      end else begin
         junk = (junk * 7 + 3) % 16;
         pair_timeout  = TW'(junk);
         third_timeout = TW'(15 - junk);
      end
      @(posedge clk);
      if (ld) begin
         started = 1;
         ticks   = 0;
         cap_p   = p;
         cap_t   = t;
      end else if (tk && ticks < 1000) begin
         ticks++;
      end
      #1;
      check_all(ctx);
      if (ld) begin
         chk(sw_pair_closed && sw_third_closed && cp_sel == WIDE, 1, {ctx, " wide after load R2"});
      end
   endtask

   initial begin
      #(4 * 190000);
      fails++;
      total++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check_all("R1 reset");
      @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < 6; i++) step(0, i[0], 0, 0, "R3 idle ticks before load");

      for (int p = 0; p < 16; p++) begin
         for (int t = 0; t < 16; t++) begin
            int gap;
            gap = ((p + t) % 3) + 1;
            step(1, ((p ^ t) & 1) == 1, p, t, "R7 sweep load");
            for (int c = 0; c < 3 * 19; c++) begin
               step(0, (c % gap) == 0, 0, 0, "R10 sweep gaps");
            end
            for (int c = 0; c < 3; c++) step(0, 1, 0, 0, "R3 ticks after settle");
         end
      end

      step(1, 0, 10, 12, "R8 first load");
      for (int c = 0; c < 5; c++) step(0, 1, 0, 0, "R8 partial run");
      step(1, 1, 2, 0, "R8 reload mid sequence");
      for (int c = 0; c < 8; c++) step(0, 1, 0, 0, "R8 restarted run");

      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule